// File: doc/BRIEF.md
# Slack-Banking DVFS Controller

This controller sits beside one processor of a real-time multi-core system. Each time a task finishes, the controller receives that task's worst-case cycle budget and the number of cycles it actually used. It adds the difference to a per-processor slack bank. A task that runs over its budget draws the bank down. When the next task is dispatched on the same processor, the controller decides whether that task runs at full speed or at a slowed, low-power operating point. Slack left behind by earlier tasks is therefore not lost at join points in the application.

Changes of operating point are kept rare. A task only runs slowed when the banked slack has reached a programmable threshold. The bank must also cover the extra time the slowed run costs, which is the task's budget times (SLOW_FACTOR - 1). That amount is then taken from the bank. A change is sent as a held request with an acknowledge. Only one request may be outstanding. After each acknowledged change, a minimum dwell time must pass before the next change may be issued.

Top module: `slack_dvfs_ctrl`

## Requirements
- R1: While rst_ni is low and right after it, req_o is 0, op_o and op_req_o are 0 (full speed), and slack_o is 0.
- R2: A completion (done_valid_i) with no dispatch in the same cycle changes slack_o by done_budget_i - done_actual_i, visible after the next rising edge. With neither input asserted, slack_o holds.
- R3: If a completion's actual time exceeds its budget, the bank shrinks by the overrun and saturates at 0 instead of wrapping.
- R4: On dispatch, the slow point (1) is wanted only if slack_o >= thresh_i and slack_o >= disp_budget_i*(SLOW_FACTOR-1). Otherwise full speed (0) is wanted. Wanting the point already targeted issues no request.
- R5: A dispatch that wants a point different from op_req_o raises req_o with op_req_o set to that point after the edge, provided no request is pending and the dwell time has expired.
- R6: req_o and op_req_o hold until an edge with ack_i high. op_o takes op_req_o after that edge. A dispatch while a request is pending issues no new request.
- R7: For MIN_DWELL cycles after an acknowledged change, a dispatch that wants a different point issues no request.
- R8: Every dispatch whose task ends up targeted at the slow point deducts disp_budget_i*(SLOW_FACTOR-1) from the bank, saturating at 0. A dispatch targeted at full speed deducts nothing.
- R9: When a completion and a dispatch coincide, the decision uses the bank value from before the completion, and both the completion's gain and the dispatch's deduction are applied in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| thresh_i | input | SLACK_W | Slack threshold for choosing the slow point |
| done_valid_i | input | 1 | Task completion strobe |
| done_budget_i | input | T_W | Worst-case budget of the completed task |
| done_actual_i | input | T_W | Actual run time of the completed task |
| dispatch_i | input | 1 | Next-task dispatch strobe |
| disp_budget_i | input | T_W | Worst-case full-speed budget of the dispatched task |
| ack_i | input | 1 | Acknowledge of the pending change request |
| req_o | output | 1 | Change request, held until acknowledged |
| op_req_o | output | 1 | Requested operating point (0 full, 1 slow) |
| op_o | output | 1 | Applied operating point |
| slack_o | output | SLACK_W | Current banked slack |

## Verification
The bench sets up slack that passes the threshold but cannot cover the cost of a long task. A controller that tests only the threshold would then request the slow point and wrap the bank. It issues dispatches while a request is pending and right after an acknowledge. A controller without the pending lock or the dwell window would drop or replace requests, or change the point again at once. An overrun larger than the bank checks for wrap-around instead of a floor at zero. Simultaneous completion and dispatch show whether the decision wrongly uses the updated bank value, or whether one of the two updates is lost.

// File: rtl/slack_dvfs_pkg.sv
package slack_dvfs_pkg;
  typedef enum logic {
    OP_FAST = 1'b0,
    OP_SLOW = 1'b1
  } op_e;
endpackage

// File: rtl/slack_bank.sv
module slack_bank #(
  parameter int SLACK_W = 16,
  parameter int T_W     = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               add_en_i,
  input  logic [T_W-1:0]     budget_i,
  input  logic [T_W-1:0]     actual_i,
  input  logic               take_en_i,
  input  logic [SLACK_W-1:0] take_amt_i,
  output logic [SLACK_W-1:0] slack_o
);
  localparam int CALC_W = SLACK_W + 2;
  localparam logic signed [CALC_W-1:0] MAX_S = $signed({2'b00, {SLACK_W{1'b1}}});

  logic [SLACK_W-1:0] slack_q;
  logic signed [CALC_W-1:0] gain, take, sum;

  always_comb begin
    gain = '0;
    take = '0;
    if (add_en_i)
      gain = $signed({{(CALC_W-T_W){1'b0}}, budget_i})
           - $signed({{(CALC_W-T_W){1'b0}}, actual_i});
    if (take_en_i)
      take = $signed({2'b00, take_amt_i});
    sum = $signed({2'b00, slack_q}) + gain - take;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              slack_q <= '0;
    else if (sum < 0)         slack_q <= '0;
    else if (sum > MAX_S)     slack_q <= {SLACK_W{1'b1}};
    else                      slack_q <= sum[SLACK_W-1:0];
  end

  assign slack_o = slack_q;
endmodule

// File: rtl/dwell_timer.sv
module dwell_timer #(
  parameter int MIN_DWELL = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(MIN_DWELL + 1);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(MIN_DWELL);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= LOAD_V;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/op_req_port.sv
module op_req_port
  import slack_dvfs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  op_e  target_i,
  input  logic ack_i,
  output logic req_o,
  output op_e  op_req_o,
  output op_e  op_o,
  output logic applied_o
);
  logic req_q;
  op_e  op_req_q, op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= 1'b0;
      op_req_q <= OP_FAST;
      op_q     <= OP_FAST;
    end else if (req_q && ack_i) begin
      req_q <= 1'b0;
      op_q  <= op_req_q;
    end else if (issue_i && !req_q) begin
      req_q    <= 1'b1;
      op_req_q <= target_i;
    end
  end

  assign req_o     = req_q;
  assign op_req_o  = op_req_q;
  assign op_o      = op_q;
  assign applied_o = req_q && ack_i;
endmodule

// File: rtl/slack_dvfs_ctrl.sv
module slack_dvfs_ctrl
  import slack_dvfs_pkg::*;
#(
  parameter int SLACK_W     = 16,
  parameter int T_W         = 12,
  parameter int SLOW_FACTOR = 2,
  parameter int MIN_DWELL   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SLACK_W-1:0] thresh_i,
  input  logic               done_valid_i,
  input  logic [T_W-1:0]     done_budget_i,
  input  logic [T_W-1:0]     done_actual_i,
  input  logic               dispatch_i,
  input  logic [T_W-1:0]     disp_budget_i,
  input  logic               ack_i,
  output logic               req_o,
  output logic               op_req_o,
  output logic               op_o,
  output logic [SLACK_W-1:0] slack_o
);
  localparam logic [31:0] STRETCH   = 32'(SLOW_FACTOR - 1);
  localparam logic [31:0] SLACK_MAX = 32'((64'd1 << SLACK_W) - 1);

  logic [31:0]        cost_full;
  logic [SLACK_W-1:0] cost, slack;
  logic               want_slow, issue, runs_slow, applied, busy, req;
  op_e                want, cur_tgt, op_app;

  // cost of a slowed run = extra cycles beyond its full-speed budget
  always_comb begin
    cost_full = 32'(disp_budget_i) * STRETCH;
    cost      = (cost_full > SLACK_MAX) ? {SLACK_W{1'b1}} : cost_full[SLACK_W-1:0];
    want_slow = (slack >= thresh_i) && (slack >= cost);
    want      = want_slow ? OP_SLOW : OP_FAST;
    issue     = dispatch_i && (want != cur_tgt) && !req && !busy;
    runs_slow = dispatch_i && ((issue ? want : cur_tgt) == OP_SLOW);
  end

  slack_bank #(.SLACK_W(SLACK_W), .T_W(T_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .add_en_i   (done_valid_i),
    .budget_i   (done_budget_i),
    .actual_i   (done_actual_i),
    .take_en_i  (runs_slow),
    .take_amt_i (cost),
    .slack_o    (slack)
  );

  dwell_timer #(.MIN_DWELL(MIN_DWELL)) u_dwell (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (applied),
    .busy_o (busy)
  );

  op_req_port u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .issue_i   (issue),
    .target_i  (want),
    .ack_i     (ack_i),
    .req_o     (req),
    .op_req_o  (cur_tgt),
    .op_o      (op_app),
    .applied_o (applied)
  );

  assign req_o    = req;
  assign op_req_o = cur_tgt;
  assign op_o     = op_app;
  assign slack_o  = slack;
endmodule

// File: rtl/slack_dvfs_ctrl_chk.sv
module slack_dvfs_ctrl_chk #(
  parameter int SLACK_W   = 16,
  parameter int T_W       = 12,
  parameter int MIN_DWELL = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               done_valid_i,
  input logic [T_W-1:0]     done_budget_i,
  input logic [T_W-1:0]     done_actual_i,
  input logic               dispatch_i,
  input logic               ack_i,
  input logic               req_o,
  input logic               op_req_o,
  input logic               op_o,
  input logic [SLACK_W-1:0] slack_o
);
  int unsigned gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         gap_q <= MIN_DWELL;
    else if (req_o && ack_i)             gap_q <= 0;
    else if (gap_q < MIN_DWELL)          gap_q <= gap_q + 1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni)
      assert_reset_idle_R1: assert (!req_o && !op_o && !op_req_o && slack_o == '0);
  end

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_valid_i && !dispatch_i) |=> $stable(slack_o));

  assert_gain_nondec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_i && !dispatch_i && done_actual_i <= done_budget_i) |=> slack_o >= $past(slack_o));

  assert_req_differs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> (op_req_o != op_o));

  assert_req_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(op_req_o)));

  assert_op_on_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_o && ack_i) |=> $stable(op_o));

  assert_dwell_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> (gap_q >= MIN_DWELL));
endmodule

bind slack_dvfs_ctrl slack_dvfs_ctrl_chk #(
  .SLACK_W(SLACK_W), .T_W(T_W), .MIN_DWELL(MIN_DWELL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_valid_i(done_valid_i),
  .done_budget_i(done_budget_i), .done_actual_i(done_actual_i),
  .dispatch_i(dispatch_i), .ack_i(ack_i), .req_o(req_o),
  .op_req_o(op_req_o), .op_o(op_o), .slack_o(slack_o)
);

// File: tb/slack_dvfs_ctrl_test.sv
`timescale 1ns/1ps
module slack_dvfs_ctrl_test;
  localparam int SLACK_W   = 16;
  localparam int T_W       = 12;
  localparam int MIN_DWELL = 8;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic [SLACK_W-1:0] thresh = '0;
  logic               done_valid = 1'b0;
  logic [T_W-1:0]     done_budget = '0, done_actual = '0;
  logic               dispatch = 1'b0;
  logic [T_W-1:0]     disp_budget = '0;
  logic               ack = 1'b0;
  logic               req, op_req, op;
  logic [SLACK_W-1:0] slack;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  slack_dvfs_ctrl #(.SLACK_W(SLACK_W), .T_W(T_W), .SLOW_FACTOR(2), .MIN_DWELL(MIN_DWELL)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .thresh_i(thresh),
    .done_valid_i(done_valid), .done_budget_i(done_budget), .done_actual_i(done_actual),
    .dispatch_i(dispatch), .disp_budget_i(disp_budget), .ack_i(ack),
    .req_o(req), .op_req_o(op_req), .op_o(op), .slack_o(slack)
  );

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic complete(input int b, input int a);
    @(negedge clk);
    done_valid = 1'b1; done_budget = T_W'(b); done_actual = T_W'(a);
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic launch(input int b);
    @(negedge clk);
    dispatch = 1'b1; disp_budget = T_W'(b);
    @(negedge clk);
    dispatch = 1'b0;
  endtask

  task automatic both(input int db, input int da, input int b);
    @(negedge clk);
    done_valid = 1'b1; done_budget = T_W'(db); done_actual = T_W'(da);
    dispatch = 1'b1; disp_budget = T_W'(b);
    @(negedge clk);
    done_valid = 1'b0; dispatch = 1'b0;
  endtask

  task automatic give_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 req", int'(req), 0);
    check("R1 op", int'(op), 0);
    check("R1 slack", int'(slack), 0);
  endtask

  task automatic t_accumulate();
    complete(50, 20);  check("R2 gain 30", int'(slack), 30);
    complete(40, 40);  check("R2 zero gain", int'(slack), 30);
    complete(100, 10); check("R2 gain 90", int'(slack), 120);
  endtask

  task automatic t_no_change();
    thresh = 100;
    launch(200);
    check("R4 cost above bank req", int'(req), 0);
    check("R4 cost above bank slack", int'(slack), 120);
    thresh = 200;
    launch(50);
    check("R4 below thresh req", int'(req), 0);
    check("R4 below thresh slack", int'(slack), 120);
    thresh = 100;
  endtask

  task automatic t_go_slow();
    launch(50);
    check("R5 req raised", int'(req), 1);
    check("R5 op_req slow", int'(op_req), 1);
    check("R8 slow deducts", int'(slack), 70);
    check("R6 op before ack", int'(op), 0);
    repeat (3) @(negedge clk);
    check("R6 req held", int'(req), 1);
    launch(10);
    check("R6 pending no new req", int'(op_req), 1);
    check("R6 pending req stays", int'(req), 1);
    check("R8 slow target deducts", int'(slack), 60);
    give_ack();
    check("R6 req cleared", int'(req), 0);
    check("R6 op applied", int'(op), 1);
  endtask

  task automatic t_dwell();
    launch(20);
    check("R7 dwell blocks req", int'(req), 0);
    check("R7 target unchanged", int'(op_req), 1);
    check("R8 blocked slow deducts", int'(slack), 40);
    repeat (MIN_DWELL + 2) @(negedge clk);
    launch(5);
    check("R5 back to fast req", int'(req), 1);
    check("R5 back to fast op_req", int'(op_req), 0);
    check("R8 fast no deduction", int'(slack), 40);
    give_ack();
    check("R6 op fast applied", int'(op), 0);
  endtask

  task automatic t_overrun();
    complete(10, 100);
    check("R3 floor at zero", int'(slack), 0);
    complete(100, 50);
    check("R2 regain", int'(slack), 50);
  endtask

  task automatic t_same_cycle();
    repeat (MIN_DWELL + 2) @(negedge clk);
    both(100, 0, 10);
    check("R9 old bank decides req", int'(req), 0);
    check("R9 gain applied", int'(slack), 150);
    both(30, 0, 20);
    check("R9 req on old bank", int'(req), 1);
    check("R9 op_req slow", int'(op_req), 1);
    check("R9 gain and deduct", int'(slack), 160);
    give_ack();
    check("R6 op slow applied", int'(op), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_accumulate();
    t_no_change();
    t_go_slow();
    t_dwell();
    t_overrun();
    t_same_cycle();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule